// File: doc/BRIEF.md
# Timer interrupt flag and encoder

This block holds the interrupt flags of a capture/compare timer unit and turns them into a priority code and a single interrupt request. Hardware strobes (timer overflow, two capture channels, and four compare channels) each set a sticky flag. Software reads the flag byte and clears a flag by writing 0 to its bit. Writing 1 leaves that bit alone.

A compare flag is raised internally. On a timer update strobe, the 16-bit timer value is checked against each channel's 16-bit compare value. A 3-bit code names the most urgent pending flag, so a service routine can branch without scanning the byte. One registered request line is driven when any pending flag is also enabled, and both the global and the unit enables are 1.

Top module: `tif_unit`

## Requirements
- R1: After reset, the flag byte, the code port and the request are all 0.
- R2: Flag bit positions are: bit 0 capture A, bit 1 capture B, bits 3..6 compare A..D, bit 7 overflow. A strobe sets its bit, and the bit is visible after the next clock edge.
- R3: Bit 2 is reserved. It always reads 0 and ignores writes.
- R4: A flag stays set until software writes 0 to that bit. It is then 0 after the write's clock edge.
- R5: Writing 1 to a flag bit leaves that bit unchanged.
- R6: If a set strobe and a write of 0 hit the same bit in the same cycle, the bit ends up set.
- R7: The code port reads as follows: 0 when no flag is set, 1 compare D, 2 compare C, 3 compare B, 4 compare A, 5 capture B, 6 capture A, 7 overflow. Bits 7..3 of the code port are always 0.
- R8: With several flags set, the code reports the highest one in this order: overflow, capture A, capture B, compare A, B, C, D (lowest).
- R9: A compare flag sets only in a cycle where the timer update strobe is 1, that channel's compare enable is 1, and the timer value equals that channel's compare value.
- R10: The request is a register. One cycle after the flags change, it equals the OR of (flag AND its request enable bit), gated by the global and unit enables.
- R11: The request is 0 whenever the global enable or the unit enable was 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovf_evt_i | input | 1 | Timer overflow strobe |
| cap_evt_i | input | 2 | Capture strobes (bit 0 = A, bit 1 = B) |
| tmr_tick_i | input | 1 | Timer value updated this cycle |
| tmr_val_i | input | 16 | Current timer value |
| cmp_val_i | input | 64 | Compare values, channel k at bits [16k+15:16k], A = 0 |
| cmp_en_i | input | 4 | Compare channel enables, bit 0 = A |
| wr_en_i | input | 1 | Flag byte write strobe |
| wr_data_i | input | 8 | Write data: 0 clears a bit, 1 keeps it |
| irq_en_i | input | 8 | Per-flag request enables, same bit layout as flags |
| glb_en_i | input | 1 | Global interrupt enable |
| unit_en_i | input | 1 | Unit interrupt enable |
| flags_o | output | 8 | Flag byte read port |
| enc_o | output | 8 | Priority code read port, upper 5 bits 0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A corrupted flag bit shows up on flags_o right after the edge that wrote it. In the same cycle it also shows on enc_o whenever that bit is the highest one set. A wrong bit position, a lost set-over-clear race, or a reserved bit that can be written therefore shows up within one cycle. Gating faults in the request path show one cycle later on irq_o. These are exposed by toggling each enable while a single known flag is pending.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned NUM_CAP = 2;
  localparam int unsigned NUM_CMP = 4;

  localparam int unsigned BIT_CAP0 = 0;
  localparam int unsigned BIT_RSVD = 2;
  localparam int unsigned BIT_CMP0 = 3;
  localparam int unsigned BIT_OVF  = 7;

  localparam logic [FLAG_W-1:0] FLAG_MASK = ~(FLAG_W'(1) << BIT_RSVD);

  // Highest pending source; 0 = none.
  function automatic logic [CODE_W-1:0] prio_code(input logic [FLAG_W-1:0] f);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int k = NUM_CMP - 1; k >= 0; k--)
      if (f[BIT_CMP0 + k]) c = CODE_W'(NUM_CMP - k);
    for (int k = NUM_CAP - 1; k >= 0; k--)
      if (f[BIT_CAP0 + k]) c = CODE_W'(NUM_CMP + NUM_CAP - k);
    if (f[BIT_OVF]) c = '1;
    return c;
  endfunction
endpackage

// File: rtl/tif_cmp_detect.sv
module tif_cmp_detect #(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned N_CH  = 4
) (
  input  logic                    tick_i,
  input  logic [TMR_W-1:0]        tmr_val_i,
  input  logic [N_CH*TMR_W-1:0]   cmp_val_i,
  input  logic [N_CH-1:0]         cmp_en_i,
  output logic [N_CH-1:0]         hit_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic eq;
    assign eq       = (tmr_val_i == cmp_val_i[k*TMR_W +: TMR_W]);
    assign hit_o[k] = tick_i & cmp_en_i[k] & eq;
  end
endmodule

// File: rtl/tif_flag_reg.sv
module tif_flag_reg #(
  parameter int unsigned           W    = 8,
  parameter logic [W-1:0]          MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flag_q, flag_d, kept;

  assign kept   = wr_en_i ? (flag_q & wr_data_i) : flag_q;
  assign flag_d = (kept | set_i) & MASK;  // set beats clear

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    if (MASK[b]) begin : g_live
      AST_SET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[b] |=> flag_q[b]);  // R2
      AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_data_i[b] && !set_i[b]) |=> !flag_q[b]);  // R4
      AST_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q[b] && !(wr_en_i && !wr_data_i[b])) |=> flag_q[b]);  // R5
      AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i[b] && wr_en_i && !wr_data_i[b]) |=> flag_q[b]);  // R6
    end
  end
endmodule

// File: rtl/tif_prio_enc.sv
module tif_prio_enc
  import tif_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb code_o = prio_code(flags_i);

  always_comb begin
    AST_ENC_IDLE: assert ((flags_i != '0) || (code_o == '0));  // R7
    AST_ENC_OVF_TOP: assert (!flags_i[BIT_OVF] || (code_o == '1));  // R8
  end
endmodule

// File: rtl/tif_unit.sv
module tif_unit
  import tif_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ovf_evt_i,
  input  logic [NUM_CAP-1:0]        cap_evt_i,
  input  logic                      tmr_tick_i,
  input  logic [TMR_W-1:0]          tmr_val_i,
  input  logic [NUM_CMP*TMR_W-1:0]  cmp_val_i,
  input  logic [NUM_CMP-1:0]        cmp_en_i,
  input  logic                      wr_en_i,
  input  logic [FLAG_W-1:0]         wr_data_i,
  input  logic [FLAG_W-1:0]         irq_en_i,
  input  logic                      glb_en_i,
  input  logic                      unit_en_i,
  output logic [FLAG_W-1:0]         flags_o,
  output logic [FLAG_W-1:0]         enc_o,
  output logic                      irq_o
);
  logic [NUM_CMP-1:0] cmp_hit;
  logic [FLAG_W-1:0]  set_vec, flags;
  logic [CODE_W-1:0]  code;
  logic               irq_q, irq_d;

  tif_cmp_detect #(.TMR_W(TMR_W), .N_CH(NUM_CMP)) u_cmp (
    .tick_i   (tmr_tick_i),
    .tmr_val_i(tmr_val_i),
    .cmp_val_i(cmp_val_i),
    .cmp_en_i (cmp_en_i),
    .hit_o    (cmp_hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[BIT_OVF] = ovf_evt_i;
    set_vec[BIT_CAP0 +: NUM_CAP] = cap_evt_i;
    set_vec[BIT_CMP0 +: NUM_CMP] = cmp_hit;
  end

  tif_flag_reg #(.W(FLAG_W), .MASK(FLAG_MASK)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .flags_o  (flags)
  );

  tif_prio_enc u_enc (
    .flags_i(flags),
    .code_o (code)
  );

  assign irq_d = glb_en_i & unit_en_i & (|(flags & irq_en_i & FLAG_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign flags_o = flags;
  assign enc_o   = {{(FLAG_W-CODE_W){1'b0}}, code};
  assign irq_o   = irq_q;

  AST_RSVD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_RSVD]) |=> !flags_o[BIT_RSVD]);  // R3
  AST_CMP_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_tick_i && !flags_o[BIT_CMP0] && !wr_en_i) |=> !flags_o[BIT_CMP0]);  // R9
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glb_en_i && unit_en_i) |=> !irq_o);  // R11
  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && unit_en_i && flags_o[BIT_OVF] && irq_en_i[BIT_OVF]) |=> irq_o);  // R10
endmodule

// File: tb/tif_unit_test.sv
module tif_unit_test;
  localparam int unsigned CLK_PER = 10;
  localparam int unsigned WD_CYC  = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ovf_evt_i = 1'b0;
  logic [1:0]  cap_evt_i = '0;
  logic        tmr_tick_i = 1'b0;
  logic [15:0] tmr_val_i = '0;
  logic [63:0] cmp_val_i = '0;
  logic [3:0]  cmp_en_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  irq_en_i = '0;
  logic        glb_en_i = 1'b0;
  logic        unit_en_i = 1'b0;
  logic [7:0]  flags_o, enc_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  tif_unit uut (
    .clk_i, .rst_ni, .ovf_evt_i, .cap_evt_i, .tmr_tick_i, .tmr_val_i,
    .cmp_val_i, .cmp_en_i, .wr_en_i, .wr_data_i, .irq_en_i, .glb_en_i,
    .unit_en_i, .flags_o, .enc_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // bits: 7 ovf, 1 cap B, 0 cap A
  task automatic pulse(input logic [7:0] b);
    ovf_evt_i = b[7];
    cap_evt_i = b[1:0];
    step();
    ovf_evt_i = 1'b0;
    cap_evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic cmp_fire(input int ch);
    tmr_val_i = 16'h1230 + 16'(ch);
    cmp_val_i[ch*16 +: 16] = 16'h1230 + 16'(ch);
    cmp_en_i = 4'b1 << ch;
    tmr_tick_i = 1'b1;
    step();
    tmr_tick_i = 1'b0;
    cmp_en_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", flags_o, 0);
    chk("R1 enc", enc_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_map();
    pulse(8'h01); chk("R2 capA bit", flags_o, 8'h01); chk("R7 capA code", enc_o, 6);
    wr(8'h00);    chk("R4 clear", flags_o, 0);
    pulse(8'h02); chk("R2 capB bit", flags_o, 8'h02); chk("R7 capB code", enc_o, 5);
    wr(8'h00);
    pulse(8'h80); chk("R2 ovf bit", flags_o, 8'h80); chk("R7 ovf code", enc_o, 7);
    wr(8'h00);
    for (int k = 0; k < 4; k++) begin
      cmp_fire(k);
      chk("R2 cmp bit", flags_o, 32'h8 << k);
      chk("R7 cmp code", enc_o, 4 - k);
      wr(8'h00);
    end
    chk("R7 idle", enc_o, 0);
  endtask

  task automatic t_sticky();
    pulse(8'h01);
    step(); step();
    chk("R4 sticky", flags_o, 8'h01);
    wr(8'h00);
    chk("R4 cleared", flags_o, 0);
  endtask

  task automatic t_rsvd();
    wr(8'hFF); chk("R3 rsvd write", flags_o, 0);
    wr(8'h04); chk("R3 rsvd only", flags_o, 0);
  endtask

  task automatic t_w1();
    pulse(8'h81);
    wr(8'hFF); chk("R5 write ones", flags_o, 8'h81);
    wr(8'hFE); chk("R5 partial", flags_o, 8'h80);
    wr(8'h00);
  endtask

  task automatic t_race();
    pulse(8'h02);
    wr_en_i = 1'b1; wr_data_i = 8'h00; cap_evt_i = 2'b01;
    step();
    wr_en_i = 1'b0; cap_evt_i = '0;
    chk("R6 set wins", flags_o, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_prio();
    pulse(8'h83);
    for (int k = 0; k < 4; k++) cmp_fire(k);
    chk("R8 all set", flags_o, 8'hFB);
    chk("R8 top ovf", enc_o, 7);
    wr(8'h7F); chk("R8 capA next", enc_o, 6);
    wr(8'h7E); chk("R8 capB next", enc_o, 5);
    wr(8'h7C); chk("R8 cmpA next", enc_o, 4);
    wr(8'h74); chk("R8 cmpB next", enc_o, 3);
    wr(8'h64); chk("R8 cmpC next", enc_o, 2);
    wr(8'h44); chk("R8 cmpD last", enc_o, 1);
    wr(8'h00); chk("R7 upper zero", enc_o & 8'hF8, 0);
  endtask

  task automatic t_cmp_gate();
    tmr_val_i = 16'h5555; cmp_val_i[15:0] = 16'h5554; cmp_en_i = 4'b0001; tmr_tick_i = 1'b1;
    step(); chk("R9 mismatch", flags_o, 0);
    cmp_val_i[15:0] = 16'h5555; cmp_en_i = 4'b1110;
    step(); chk("R9 disabled", flags_o, 0);
    cmp_en_i = 4'b0001; tmr_tick_i = 1'b0;
    step(); chk("R9 no tick", flags_o, 0);
    tmr_tick_i = 1'b1;
    step(); chk("R9 match", flags_o, 8'h08);
    tmr_tick_i = 1'b0; cmp_en_i = '0;
    wr(8'h00);
  endtask

  task automatic t_irq();
    glb_en_i = 1'b1; unit_en_i = 1'b1; irq_en_i = 8'h80;
    pulse(8'h80);
    chk("R10 one cycle lag", irq_o, 0);
    step(); chk("R10 raised", irq_o, 1);
    glb_en_i = 1'b0; step(); chk("R11 global off", irq_o, 0);
    glb_en_i = 1'b1; unit_en_i = 1'b0; step(); chk("R11 unit off", irq_o, 0);
    unit_en_i = 1'b1; irq_en_i = 8'h01; step(); chk("R10 other enable", irq_o, 0);
    irq_en_i = 8'h80; step(); chk("R10 back on", irq_o, 1);
    wr(8'h00); step(); chk("R10 cleared", irq_o, 0);
    irq_en_i = 8'h04; wr(8'hFF); step(); chk("R3 rsvd no irq", irq_o, 0);
    glb_en_i = 1'b0; unit_en_i = 1'b0; irq_en_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_map();
    t_sticky();
    t_rsvd();
    t_w1();
    t_race();
    t_prio();
    t_cmp_gate();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule